// File: doc/BRIEF.md
# Interrupt Event Queue Writer with Generation Bit

This block takes a stream of accepted interrupt event numbers and stores each one as a 32-bit word in a circular queue held in ordinary memory. The queue holds a power-of-two number of entries. Its base address and size are supplied as configuration inputs. The write index wraps with a mask, and the top bit of every word is a generation bit that the writer inverts each time its index returns to zero.

A consumer walks the same queue with its own index and its own toggle bit. It treats an entry as fresh only when the entry's top bit differs from its toggle, and it inverts the toggle whenever its own index wraps. No shared tail pointer is needed.

The writer issues one word write per stored event on a simple request/acknowledge memory port. It emits a notification pulse once that write has been acknowledged. The event input is held off while a write is outstanding.

Top module: `evq_writer`

## Requirements
- R1: After reset, `mem_req` and `notify` are low and `ev_ready` is high. The first stored event goes to index 0 with generation bit 1, so a zero-filled queue reads as empty to a consumer whose toggle starts at 0.
- R2: The logical entry is {generation, payload[30:0]}, with the generation bit at bit 31. With BIG_ENDIAN=1 (default), `mem_wdata` carries this word byte-reversed: `mem_wdata[7:0]` holds logical bits 31:24 and `mem_wdata[31:24]` holds logical bits 7:0.
- R3: Each stored event produces exactly one write at `base + 4*index`, and the index then advances by one.
- R4: The queue holds 2^L entries. The index wraps to 0 through a mask of 2^L-1, and the generation bit inverts at each wrap.
- R5: The size code L on `cfg_log2` is clamped to the range MIN_LOG2..MAX_LOG2 (defaults 2 and 10). A code of 0 gives a 4-entry queue, and a code of 15 gives 1024 entries.
- R6: From the edge that accepts an event until the edge that sees `mem_ack`, `mem_req` stays high with `mem_addr` and `mem_wdata` held steady, and `ev_ready` stays low.
- R7: `notify` is high for exactly one cycle, the cycle after the edge at which `mem_ack` completes a write. There is one pulse per write.
- R8: An event with number 0 and `ev_ipi` low is accepted and dropped. It causes no write, no notification and no index advance.
- R9: An event with `ev_ipi` high is stored with payload 2^24, whatever `ev_num` holds.
- R10: Any change of `cfg_base` or `cfg_log2` makes `ev_ready` low for that cycle. It also returns the index to 0 and the generation bit to 1.
- R11: A consumer following the toggle rule reads every stored event exactly once, in order, across several wraps, and finds the queue empty once it has caught up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Queue base address, aligned to the queue size |
| cfg_log2 | input | SZ_W | Log2 of the entry count, clamped |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_num | input | 31 | Event number |
| ev_ipi | input | 1 | Store the inter-processor marker instead of ev_num |
| mem_req | output | 1 | Word write request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Entry in memory byte order |
| mem_ack | input | 1 | Write completed this cycle |
| notify | output | 1 | One-cycle pulse after each completed write |

## Verification
The main function is driven by a vector table that mixes plain event numbers, marker events and null events, with acknowledge latencies of 0 to 2 cycles. The table runs on a 4-entry queue, so the index wraps twice and the generation bit is exercised in both polarities. A consumer model reads the queue after every write. An entry written with a stale generation would show up either as a missing event or as a phantom one.

Directed runs cover the remaining behaviour. The clamp is tried at both ends: one run fills a full 1024-entry pass and checks that the next write lands on the base with generation 0. Another run changes the base address mid-stream, and a final run applies reset after partial use. Together these separate the index and generation restart from a plain wrap.

// File: rtl/evq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the event queue writer.
package evq_pkg;

    localparam int ENTRY_W   = 32;
    localparam int PAYLOAD_W = 31;

    // Write path state: idle, or waiting for the memory acknowledge.
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_t;

    // Reverse the byte order of one entry word.
    function automatic logic [ENTRY_W-1:0] bswap32(input logic [ENTRY_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/evq_index.sv
`timescale 1ns/1ps
// Tracks the write index and generation bit of the circular queue.
// It registers the queue configuration and restarts on any change of it.
// Assumes cfg_base is aligned to the queue size and ADDR_W > MAX_LOG2 + 2.
module evq_index #(
    parameter int ADDR_W   = 32,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 10,
    parameter int SZ_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_log2,
    input  logic              advance,
    output logic              cfg_chg,
    output logic              gen,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int IDX_W = MAX_LOG2;
    localparam int PAD_W = ADDR_W - IDX_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [SZ_W-1:0]   log2_q;
    logic [SZ_W-1:0]   log2_eff;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_nxt;
    logic [IDX_W-1:0]  mask;

    // Detect a new base or size against the registered copy.
    assign cfg_chg = (cfg_base != base_q) || (cfg_log2 != log2_q);

    // Clamp the size code into the supported range.
    always_comb begin
        if (log2_q < SZ_W'(MIN_LOG2)) begin
            log2_eff = SZ_W'(MIN_LOG2);
        end else if (log2_q > SZ_W'(MAX_LOG2)) begin
            log2_eff = SZ_W'(MAX_LOG2);
        end else begin
            log2_eff = log2_q;
        end
    end

    // Build the wrap mask one bit at a time.
    genvar gi;
    generate
        for (gi = 0; gi < IDX_W; gi++) begin : g_mask
            assign mask[gi] = (int'(log2_eff) > gi);
        end
    endgenerate

    // Next index after this write, wrapped by the mask.
    assign idx_nxt = (idx + IDX_W'(1)) & mask;

    // Byte address of the current slot.
    assign wr_addr = base_q + {{PAD_W{1'b0}}, idx, 2'b00};

    // Index, generation and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            gen    <= 1'b1;
            base_q <= cfg_base;
            log2_q <= cfg_log2;
        end else if (cfg_chg) begin
            idx    <= '0;
            gen    <= 1'b1;
            base_q <= cfg_base;
            log2_q <= cfg_log2;
        end else if (advance) begin
            idx <= idx_nxt;
            if (idx_nxt == '0) begin
                gen <= ~gen;
            end
        end
    end

endmodule

// File: rtl/evq_format.sv
`timescale 1ns/1ps
// Forms the queue entry: generation bit over a 31-bit payload.
// It substitutes the inter-processor marker when asked and reports null payloads.
// Assumes IPI_VALUE is nonzero and fits in 31 bits.
module evq_format
    import evq_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int IPI_VALUE  = 32'h0100_0000
) (
    input  logic                 gen,
    input  logic [PAYLOAD_W-1:0] ev_num,
    input  logic                 ev_ipi,
    output logic                 is_null,
    output logic [ENTRY_W-1:0]   word
);
    localparam logic [PAYLOAD_W-1:0] IPI_MARK = PAYLOAD_W'(IPI_VALUE);

    logic [PAYLOAD_W-1:0] payload;
    logic [ENTRY_W-1:0]   logical;

    // Pick the payload and flag the reserved empty value.
    always_comb begin
        payload = ev_ipi ? IPI_MARK : ev_num;
        is_null = (payload == '0);
        logical = {gen, payload};
    end

    // Choose the memory byte order.
    generate
        if (BIG_ENDIAN) begin : g_be
            assign word = bswap32(logical);
        end else begin : g_le
            assign word = logical;
        end
    endgenerate

endmodule

// File: rtl/evq_memif.sv
`timescale 1ns/1ps
// Holds one word write on the memory port until it is acknowledged.
// It then pulses notify for one cycle.
// Assumes start is only raised while busy is low.
module evq_memif
    import evq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [ENTRY_W-1:0] data_in,
    input  logic               mem_ack,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               notify
);
    wr_state_t state;

    assign busy    = (state == WR_BUSY);
    assign mem_req = busy;

    // Request sequencing and notification pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WR_IDLE;
            mem_addr  <= '0;
            mem_wdata <= '0;
            notify    <= 1'b0;
        end else begin
            notify <= 1'b0;
            case (state)
                WR_IDLE: begin
                    if (start) begin
                        mem_addr  <= addr_in;
                        mem_wdata <= data_in;
                        state     <= WR_BUSY;
                    end
                end
                WR_BUSY: begin
                    if (mem_ack) begin
                        state  <= WR_IDLE;
                        notify <= 1'b1;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evq_writer.sv
`timescale 1ns/1ps
// Event queue writer: stores accepted event numbers as generation-tagged words
// in a power-of-two circular queue and notifies after each completed write.
// Assumes one write outstanding at a time and a base aligned to the queue size.
module evq_writer
    import evq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MIN_LOG2   = 2,
    parameter int MAX_LOG2   = 10,
    parameter int SZ_W       = 4,
    parameter bit BIG_ENDIAN = 1'b1,
    parameter int IPI_VALUE  = 32'h0100_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [SZ_W-1:0]      cfg_log2,
    input  logic                 ev_valid,
    output logic                 ev_ready,
    input  logic [PAYLOAD_W-1:0] ev_num,
    input  logic                 ev_ipi,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [ENTRY_W-1:0]   mem_wdata,
    input  logic                 mem_ack,
    output logic                 notify
);
    logic              cfg_chg;
    logic              gen;
    logic [ADDR_W-1:0] slot_addr;
    logic              is_null;
    logic [ENTRY_W-1:0] word;
    logic              busy;
    logic              accept;
    logic              write_go;

    // Accept only when idle and the configuration is settled.
    assign ev_ready = !busy && !cfg_chg;
    assign accept   = ev_valid && ev_ready;
    assign write_go = accept && !is_null;

    evq_index #(
        .ADDR_W  (ADDR_W),
        .MIN_LOG2(MIN_LOG2),
        .MAX_LOG2(MAX_LOG2),
        .SZ_W    (SZ_W)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_base(cfg_base),
        .cfg_log2(cfg_log2),
        .advance (write_go),
        .cfg_chg (cfg_chg),
        .gen     (gen),
        .wr_addr (slot_addr)
    );

    evq_format #(
        .BIG_ENDIAN(BIG_ENDIAN),
        .IPI_VALUE (IPI_VALUE)
    ) u_format (
        .gen    (gen),
        .ev_num (ev_num),
        .ev_ipi (ev_ipi),
        .is_null(is_null),
        .word   (word)
    );

    evq_memif #(
        .ADDR_W(ADDR_W)
    ) u_memif (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (write_go),
        .addr_in  (slot_addr),
        .data_in  (word),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .notify   (notify)
    );

endmodule

// File: rtl/evq_writer_chk.sv
`timescale 1ns/1ps
// Protocol checks on the event queue writer ports, bound to every instance.
module evq_writer_chk
    import evq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_ready,
    input logic               mem_req,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [ENTRY_W-1:0] mem_wdata,
    input logic               mem_ack,
    input logic               notify
);
    logic [ENTRY_W-1:0] logical;
    assign logical = BIG_ENDIAN ? bswap32(mem_wdata) : mem_wdata;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_req && !notify)); // R1

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ev_ready); // R6

    AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> $past(mem_req && mem_ack)); // R7

    AST_NOTIFY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> notify); // R7

    AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        notify |=> !notify); // R7

    AST_NO_NULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (logical[30:0] != '0)); // R8

endmodule

bind evq_writer evq_writer_chk #(
    .ADDR_W    (ADDR_W),
    .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_ready (ev_ready),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .notify   (notify)
);

// File: tb/tb_evq_writer.sv
`timescale 1ns/1ps
module tb_evq_writer;

    localparam int ADDR_W = 32;
    localparam int SZ_W   = 4;
    localparam logic [30:0] IPI_MARK = 31'h0100_0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] cfg_base;
    logic [SZ_W-1:0]   cfg_log2;
    logic              ev_valid;
    logic              ev_ready;
    logic [30:0]       ev_num;
    logic              ev_ipi;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ack;
    logic              notify;

    always #2.5 clk = ~clk;

    evq_writer dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_log2(cfg_log2),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_num(ev_num), .ev_ipi(ev_ipi),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .notify(notify)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Memory and responder state.
    logic [31:0] qmem [1024];
    int          ack_lat = 0;
    int          wait_cnt = 0;
    int          wr_cnt = 0;
    int          nt_cnt = 0;
    logic [ADDR_W-1:0] last_addr;
    logic [31:0]       last_data;

    // Producer model and consumer model.
    int   m_idx, m_entries;
    bit   m_gen;
    int   rd_idx;
    bit   rd_tog;

    // Vector table: {ipi, event number}.
    localparam logic [31:0] VEC [12] = '{
        {1'b0, 31'd5},     {1'b0, 31'd17},    {1'b1, 31'd0},
        {1'b0, 31'd0},     {1'b0, 31'h7fff_ffff}, {1'b0, 31'd3},
        {1'b1, 31'd99},    {1'b0, 31'd42},    {1'b0, 31'd0},
        {1'b0, 31'h0012_3456}, {1'b0, 31'd1}, {1'b0, 31'd8}
    };

    function automatic logic [31:0] swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: acks after ack_lat idle cycles and records the write.
    initial begin
        mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt >= ack_lat) begin
                    mem_ack = 1'b1;
                    wait_cnt = 0;
                    wr_cnt++;
                    last_addr = mem_addr;
                    last_data = mem_wdata;
                    qmem[int'((mem_addr - cfg_base) >> 2) & 1023] = mem_wdata;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // Notification counter.
    initial begin
        forever begin
            @(negedge clk);
            if (notify) nt_cnt++;
        end
    end

    task automatic model_restart(input int entries);
        m_entries = entries;
        m_idx = 0; m_gen = 1'b1;
        rd_idx = 0; rd_tog = 1'b0;
        for (int k = 0; k < 1024; k++) qmem[k] = 32'h0;
    endtask

    task automatic send(input logic [30:0] num, input bit ipi);
        ev_valid = 1'b1; ev_num = num; ev_ipi = ipi;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (mem_req || !ev_ready);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_entry(output logic [30:0] v);
        logic [31:0] e;
        e = swap(qmem[rd_idx]);
        if (e[31] == rd_tog) begin
            v = '0;
        end else begin
            v = e[30:0];
            rd_idx = (rd_idx + 1) % m_entries;
            if (rd_idx == 0) rd_tog = ~rd_tog;
        end
    endtask

    // Send one event and check write, notify and consumer view.
    task automatic one_event(input logic [30:0] num, input bit ipi, input string req);
        logic [30:0] pay;
        logic [31:0] exp_word;
        logic [ADDR_W-1:0] exp_addr;
        logic [30:0] got;
        int w0, n0;
        bit null_ev;
        pay = ipi ? IPI_MARK : num;
        null_ev = (pay == 0);
        w0 = wr_cnt; n0 = nt_cnt;
        exp_addr = cfg_base + ADDR_W'(4 * m_idx);
        exp_word = swap({m_gen, pay});
        send(num, ipi);
        if (!null_ev && ack_lat > 0)
            check(mem_req && !ev_ready, "R6 busy holds request", {62'h0, mem_req, ev_ready}, 64'h2);
        wait_quiet();
        if (null_ev) begin
            check(wr_cnt == w0 && nt_cnt == n0, "R8 null dropped", wr_cnt - w0, 0);
        end else begin
            check(wr_cnt == w0 + 1, {req, " one write"}, wr_cnt - w0, 1);
            check(last_addr == exp_addr, "R3 address", last_addr, exp_addr);
            check(last_data == exp_word, {req, " entry word"}, last_data, exp_word);
            check(nt_cnt == n0 + 1, "R7 one notify", nt_cnt - n0, 1);
            m_idx = (m_idx + 1) % m_entries;
            if (m_idx == 0) m_gen = ~m_gen;
            read_entry(got);
            check(got == pay, "R11 consumer reads event", got, pay);
        end
        read_entry(got);
        check(got == 0, "R11 consumer sees empty", got, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [30:0] got;
        int w0;
        bit ok;
        rst_n = 1'b0; ev_valid = 1'b0; ev_num = '0; ev_ipi = 1'b0;
        cfg_base = 32'h0000_1000; cfg_log2 = 4'd2;
        model_restart(4);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ev_ready && !mem_req && !notify, "R1 reset outputs",
              {61'h0, ev_ready, mem_req, notify}, 64'h4);
        read_entry(got);
        check(got == 0, "R1 zero queue reads empty", got, 0);

        // Vector table on a 4-entry queue (R2 R4 R9 by payload mix).
        for (int i = 0; i < 12; i++) begin
            ack_lat = i % 3;
            one_event(VEC[i][30:0], VEC[i][31], VEC[i][31] ? "R9" : "R2 R4");
        end

        // R5 low clamp: size code 0 acts as 4 entries.
        cfg_log2 = 4'd0;
        #1;
        check(!ev_ready, "R10 ready low on size change", ev_ready, 0);
        @(negedge clk);
        model_restart(4);
        ack_lat = 0;
        for (int i = 0; i < 5; i++) one_event(31'(100 + i), 1'b0, "R5 R4");
        check(last_addr == cfg_base + 32'd0, "R5 low clamp wraps at 4", last_addr, cfg_base);

        // R10 base change mid-stream.
        cfg_base = 32'h0000_2000;
        #1;
        check(!ev_ready, "R10 ready low on base change", ev_ready, 0);
        @(negedge clk);
        check(ev_ready, "R10 ready returns", ev_ready, 1);
        model_restart(4);
        one_event(31'd77, 1'b0, "R10");
        check(last_addr == 32'h0000_2000 && last_data[7] == 1'b1, "R10 restart index and gen",
              last_addr, 32'h0000_2000);

        // R5 high clamp: size code 15 acts as 1024 entries.
        cfg_log2 = 4'd15;
        @(negedge clk); @(negedge clk);
        model_restart(1024);
        w0 = wr_cnt;
        for (int i = 0; i < 1024; i++) begin
            send(31'(i + 1), 1'b0);
            wait_quiet();
        end
        check(wr_cnt == w0 + 1024, "R3 full pass writes", wr_cnt - w0, 1024);
        ok = 1;
        for (int i = 0; i < 1024; i++) begin
            read_entry(got);
            if (got != 31'(i + 1)) ok = 0;
        end
        check(ok, "R11 full pass read in order", ok, 1);
        read_entry(got);
        check(got == 0, "R11 empty after full pass", got, 0);
        send(31'd555, 1'b0);
        wait_quiet();
        check(last_addr == cfg_base, "R5 high clamp wraps at 1024", last_addr, cfg_base);
        check(last_data == swap({1'b0, 31'd555}), "R4 generation flips to 0", last_data,
              swap({1'b0, 31'd555}));
        read_entry(got);
        check(got == 31'd555, "R11 second pass visible", got, 555);

        // R1 reset after use restarts index and generation.
        cfg_log2 = 4'd2;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_restart(4);
        one_event(31'd9, 1'b0, "R1");
        check(last_addr == cfg_base && last_data[7] == 1'b1, "R1 restart after reset",
              last_addr, cfg_base);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule